// File: doc/BRIEF.md
# Serial Master Clock Divider

This block generates the serial clock for a synchronous serial master running either a two-wire (I2C) or a four-wire (SPI) link. An 8-bit divide setting feeds a down counter. The counter advances on every second system clock. Each time it runs out, it reloads from the setting and flips the serial clock. One serial clock period therefore lasts 4 × (setting + 1) system clocks. For example, with a 32 MHz system clock a setting of 0x13 gives 400 kHz and a setting of 0x4F gives 100 kHz.

A one-cycle start strobe launches counting. It comes from the write into the transmit buffer. A done indication from the byte engine halts counting, and the clock output then keeps whatever level it had. In I2C mode three extra rules apply:

- Settings below three cannot be used. Such a setting is raised to three, and a sticky error flag is set.
- While the clock has been released high but the sensed line still reads low, the divider waits. This is the slave holding the clock low.
- The serial clock rests high after reset. In SPI mode the resting level comes from a polarity input.

Top module: `sm_brg`

## Requirements
- R1: While reset is held, and after it is released until the first start, `sclk_o` equals 1 in I2C mode (`i2c_mode_i`=1) and equals `spi_idle_i` in SPI mode (`i2c_mode_i`=0). `reload_o` and `cfg_err_o` are 0 during this time.
- R2: Take the clock edge that samples `start_i`=1. The first reload takes place 2 × (E+1) system clock edges after it, and later reloads follow at the same spacing. E is the effective setting. Counting is only suspended by the hold described in R7.
- R3: Every reload inverts `sclk_o` and drives `reload_o` high for exactly one cycle. `sclk_o` never changes outside a reload, apart from reset.
- R4: An edge that samples `done_i`=1 with `start_i`=0 stops counting. From then on `sclk_o` keeps its level and `reload_o` stays 0 until the next start.
- R5: In I2C mode a setting of 0, 1 or 2 acts as 3. In SPI mode every setting from 0 to 255 is used unchanged.
- R6: `cfg_err_o` goes to 1 when a start or a reload in I2C mode uses a setting of 0, 1 or 2. It stays at 1 until reset.
- R7: In I2C mode, counting pauses on any edge where `sclk_o`=1 and `scl_sense_i`=0. Counting resumes where it stopped once `scl_sense_i` reads 1.
- R8: A start while counting restarts the timing of R2 from that edge and leaves the `sclk_o` level unchanged.
- R9: When `start_i` and `done_i` are both 1 on the same edge, the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| reload_i | input | 8 | Divide setting |
| i2c_mode_i | input | 1 | 1 selects I2C, 0 selects SPI |
| spi_idle_i | input | 1 | Resting clock level used in SPI mode |
| start_i | input | 1 | One-cycle strobe from the transmit buffer write |
| done_i | input | 1 | Transfer finished, stop the clock |
| scl_sense_i | input | 1 | Level read back from the clock line (I2C) |
| sclk_o | output | 1 | Serial clock |
| reload_o | output | 1 | One-cycle pulse at each counter reload |
| cfg_err_o | output | 1 | Sticky illegal-setting flag (I2C) |

## Verification
The assertions assume that `i2c_mode_i` and `spi_idle_i` stay constant across the edge that releases reset. This keeps the reset-to-run clock level well defined. The stimulus changes the mode only while reset is held. It changes the divide setting only between transfers, so each transfer has one fixed half period to check against. In I2C mode the sensed line follows the expected clock except during deliberately inserted low stretches, so the hold condition arises only where a slave would create it.

// File: rtl/sm_brg_pkg.sv
package sm_brg_pkg;
    localparam int unsigned I2C_MIN_RELOAD = 3;

    typedef enum logic {
        MODE_SPI = 1'b0,
        MODE_I2C = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/sm_brg_clamp.sv
module sm_brg_clamp
    import sm_brg_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] raw_i,
    input  bus_mode_e        mode_i,
    output logic [CNT_W-1:0] eff_o,
    output logic             illegal_o
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(I2C_MIN_RELOAD);

    always_comb begin
        illegal_o = (mode_i == MODE_I2C) && (raw_i < FLOOR);
        eff_o     = illegal_o ? FLOOR : raw_i;
    end
endmodule

// File: rtl/sm_brg_hold.sv
module sm_brg_hold
    import sm_brg_pkg::*;
(
    input  bus_mode_e mode_i,
    input  logic      sclk_q_i,
    input  logic      line_i,
    output logic      hold_o
);
    always_comb begin
        hold_o = (mode_i == MODE_I2C) && sclk_q_i && !line_i;
    end
endmodule

// File: rtl/sm_brg_core.sv
module sm_brg_core
    import sm_brg_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             idle_lvl_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             load_bad_i,
    input  logic             start_i,
    input  logic             done_i,
    input  logic             hold_i,
    output logic             sclk_o,
    output logic             rld_o,
    output logic             err_o
);
    typedef struct packed {
        logic             run;
        logic             phase;
        logic [CNT_W-1:0] cnt;
        logic             sclk;
        logic             rld;
        logic             err;
    } brg_state_t;

    brg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rld = 1'b0;
        if (start_i) begin
            st_d.run   = 1'b1;
            st_d.phase = 1'b0;
            st_d.cnt   = load_i;
            st_d.err   = st_q.err | load_bad_i;
        end else if (done_i) begin
            st_d.run   = 1'b0;
            st_d.phase = 1'b0;
        end else if (st_q.run && !hold_i) begin
            st_d.phase = ~st_q.phase;
            if (st_q.phase) begin
                if (st_q.cnt == '0) begin
                    st_d.cnt  = load_i;
                    st_d.sclk = ~st_q.sclk;
                    st_d.rld  = 1'b1;
                    st_d.err  = st_q.err | load_bad_i;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.sclk  <= idle_lvl_i;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_o = st_q.sclk;
    assign rld_o  = st_q.rld;
    assign err_o  = st_q.err;
endmodule

// File: rtl/sm_brg.sv
module sm_brg
    import sm_brg_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             i2c_mode_i,
    input  logic             spi_idle_i,
    input  logic             start_i,
    input  logic             done_i,
    input  logic             scl_sense_i,
    output logic             sclk_o,
    output logic             reload_o,
    output logic             cfg_err_o
);
    bus_mode_e        mode;
    logic [CNT_W-1:0] load_eff;
    logic             load_bad;
    logic             hold;
    logic             idle_lvl;

    assign mode     = i2c_mode_i ? MODE_I2C : MODE_SPI;
    assign idle_lvl = (mode == MODE_I2C) ? 1'b1 : spi_idle_i;

    sm_brg_clamp #(.CNT_W(CNT_W)) u_clamp (
        .raw_i     (reload_i),
        .mode_i    (mode),
        .eff_o     (load_eff),
        .illegal_o (load_bad)
    );

    sm_brg_hold u_hold (
        .mode_i   (mode),
        .sclk_q_i (sclk_o),
        .line_i   (scl_sense_i),
        .hold_o   (hold)
    );

    sm_brg_core #(.CNT_W(CNT_W)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .idle_lvl_i (idle_lvl),
        .load_i     (load_eff),
        .load_bad_i (load_bad),
        .start_i    (start_i),
        .done_i     (done_i),
        .hold_i     (hold),
        .sclk_o     (sclk_o),
        .rld_o      (reload_o),
        .err_o      (cfg_err_o)
    );
endmodule

// File: rtl/sm_brg_chk.sv
module sm_brg_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic i2c_mode_i,
    input logic start_i,
    input logic done_i,
    input logic scl_sense_i,
    input logic sclk_o,
    input logic reload_o,
    input logic cfg_err_o
);
    // R3
    reload_toggles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_o |-> (sclk_o != $past(sclk_o)));

    // R3
    toggle_needs_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o != $past(sclk_o)) |-> reload_o);

    // R2
    reload_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_o |=> !reload_o);

    // R4
    done_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !start_i) |=> (!reload_o && (sclk_o == $past(sclk_o))));

    // R6
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |=> cfg_err_o);

    // R7
    stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (i2c_mode_i && sclk_o && !scl_sense_i) |=> !reload_o);
endmodule

bind sm_brg sm_brg_chk u_sm_brg_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .i2c_mode_i  (i2c_mode_i),
    .start_i     (start_i),
    .done_i      (done_i),
    .scl_sense_i (scl_sense_i),
    .sclk_o      (sclk_o),
    .reload_o    (reload_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/sm_brg_bench.sv
module sm_brg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rld_val = 8'd5;
    logic       i2c = 1'b0;
    logic       cpol = 1'b0;
    logic       start = 1'b0;
    logic       done = 1'b0;
    logic       scl_in = 1'b1;
    logic       sclk, rld_pulse, err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // reference state
    bit m_run, m_sclk, m_rld, m_err;
    int m_el, m_half;

    always #4 clk = ~clk;

    sm_brg u_sm_brg (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reload_i    (rld_val),
        .i2c_mode_i  (i2c),
        .spi_idle_i  (cpol),
        .start_i     (start),
        .done_i      (done),
        .scl_sense_i (scl_in),
        .sclk_o      (sclk),
        .reload_o    (rld_pulse),
        .cfg_err_o   (err)
    );

    function automatic int eff_of(bit md, logic [7:0] r);
        return (md && r < 8'd3) ? 3 : int'(r);
    endfunction

    function automatic bit bad_of(bit md, logic [7:0] r);
        return md && (r < 8'd3);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit s, bit d, bit stretch, string tag);
        bit hold;
        start  = s;
        done   = d;
        scl_in = i2c ? (m_sclk & ~stretch) : 1'b1;
        hold   = i2c && m_sclk && !scl_in;
        m_rld  = 1'b0;
        if (s) begin
            m_run  = 1'b1;
            m_el   = 0;
            m_half = 2 * (eff_of(i2c, rld_val) + 1);
            m_err  = m_err | bad_of(i2c, rld_val);
        end else if (d) begin
            m_run = 1'b0;
        end else if (m_run && !hold) begin
            m_el++;
            if (m_el == m_half) begin
                m_el   = 0;
                m_sclk = ~m_sclk;
                m_rld  = 1'b1;
                m_err  = m_err | bad_of(i2c, rld_val);
            end
        end
        @(posedge clk);
        #1;
        check(tag, "sclk", int'(sclk), int'(m_sclk));
        check(tag, "reload", int'(rld_pulse), int'(m_rld));
        check(tag, "err", int'(err), int'(m_err));
        start = 1'b0;
        done  = 1'b0;
    endtask

    task automatic do_reset(bit md, bit pol);
        rst_n = 1'b0;
        i2c   = md;
        cpol  = pol;
        start = 1'b0;
        done  = 1'b0;
        scl_in = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        m_run = 1'b0; m_sclk = md ? 1'b1 : pol; m_rld = 1'b0; m_err = 1'b0;
        m_el = 0; m_half = 2;
        check("R1", "reset sclk", int'(sclk), int'(m_sclk));
        check("R1", "reset reload", int'(rld_pulse), 0);
        check("R1", "reset err", int'(err), 0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R1");
    endtask

    // run until the given number of half periods elapsed, then stop
    task automatic xfer(logic [7:0] r, int halves, int pct, string tag);
        int seen = 0;
        rld_val = r;
        step(1'b1, 1'b0, 1'b0, tag);
        while (seen < halves) begin
            step(1'b0, 1'b0, (($urandom % 100) < pct), tag);
            if (m_rld) seen++;
        end
        repeat (3) step(1'b0, 1'b0, 1'b0, tag);
        step(1'b0, 1'b1, 1'b0, "R4");
        repeat (6) step(1'b0, 1'b0, 1'b0, "R4");
    endtask

    // measures edges from a start to the first reload pulse
    task automatic measure(logic [7:0] r, int exp, string tag);
        int n = 0;
        rld_val = r;
        step(1'b1, 1'b0, 1'b0, tag);
        n = 0;
        while (!rld_pulse && n < 2000) begin
            step(1'b0, 1'b0, 1'b0, tag);
            n++;
        end
        check(tag, "edges to first reload", n, exp);
        n = 0;
        step(1'b0, 1'b0, 1'b0, tag);
        while (!rld_pulse && n < 2000) begin
            step(1'b0, 1'b0, 1'b0, tag);
            n++;
        end
        check(tag, "edges between reloads", n + 1, exp);
        step(1'b0, 1'b1, 1'b0, "R4");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL R2 watchdog: cycles=%0d expected<=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        #1;
        // SPI, polarity 1 and 0
        do_reset(1'b0, 1'b1);
        measure(8'h13, 40, "R2");
        measure(8'h00, 2, "R5");
        xfer(8'd0, 4, 0, "R5");
        check("R6", "spi zero no err", int'(err), 0);
        do_reset(1'b0, 1'b0);
        measure(8'h4F, 160, "R2");
        xfer(8'd7, 5, 0, "R3");
        // restart during run
        rld_val = 8'd4;
        step(1'b1, 1'b0, 1'b0, "R8");
        repeat (15) step(1'b0, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b0, "R8");
        repeat (12) step(1'b0, 1'b0, 1'b0, "R8");
        // start and done together
        step(1'b1, 1'b1, 1'b0, "R9");
        repeat (12) step(1'b0, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, "R4");
        // I2C
        do_reset(1'b1, 1'b0);
        xfer(8'd9, 4, 0, "R2");
        check("R6", "legal no err", int'(err), 0);
        measure(8'h01, 8, "R5");
        check("R6", "err after illegal", int'(err), 1);
        xfer(8'd20, 3, 0, "R6");
        check("R6", "err sticky", int'(err), 1);
        do_reset(1'b1, 1'b1);
        xfer(8'd2, 4, 0, "R5");
        do_reset(1'b1, 1'b0);
        xfer(8'd5, 6, 40, "R7");
        // random mix
        for (int k = 0; k < 40; k++) begin
            bit md = 1'($urandom % 2);
            if (k % 8 == 0) do_reset(md, 1'($urandom % 2));
            xfer(8'($urandom % 24), 1 + int'($urandom % 5), i2c ? 25 : 0, "R2");
        end
        do_reset(1'b0, 1'b0);
        xfer(8'd255, 2, 0, "R2");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule